// File: doc/BRIEF.md
# Three-Level Translation Buffer Hierarchy

This block turns virtual addresses into physical addresses by searching three translation buffers of growing size, smallest first. The first level (8 entries) and the second level (64 entries) are fully associative and hold pages of any of the three supported sizes. The third level (512 entries, 4-way set associative over 128 sets) holds only 4K pages and 2M pages. It never holds a 1G page. An answer from a smaller level comes back sooner. The first level answers in the cycle of the request, the second level one cycle later, the third level two cycles later, and a full miss is reported three cycles after the request.

A hit in a deeper level copies the translation upward, so a later lookup of the same page finds it sooner. An external walker services full misses through the fill port. The port takes page numbers and a 2-bit size code, and it writes the first two levels, plus the third level when the page is not 1G. A flush input empties every level in a single cycle and drops any lookup in progress. The lookup sequencer has four named states:
- `ST_IDLE` accepts a request and searches level 0.
- `ST_L1` searches level 1.
- `ST_L2` searches level 2.
- `ST_MISS` reports a full miss.

Transitions:
- A level-0 miss moves `ST_IDLE` to `ST_L1`.
- A level-1 miss moves `ST_L1` to `ST_L2`.
- A level-2 miss moves `ST_L2` to `ST_MISS`.
- Every hit, the miss report and every flush return to `ST_IDLE`.

Top module: `tlb3_hier`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, and every level is empty, so a lookup ends in a full miss.
- R2: A lookup that hits level 0 gives `rsp_valid`=1, `rsp_hit`=1 and `rsp_level`=00 in the same cycle as the accepted request.
- R3: A lookup that misses level 0 and hits level 1 responds one cycle after the request with `rsp_level`=01. The translation is copied into level 0, so the next lookup of that page answers in the request cycle.
- R4: A lookup that hits only level 2 responds two cycles after the request with `rsp_level`=10. The translation is copied into both level 0 and level 1.
- R5: A lookup that misses all levels gives `rsp_valid`=1, `rsp_miss`=1, `rsp_hit`=0 and `rsp_level`=11 three cycles after the request. Every response raises exactly one of `rsp_hit` and `rsp_miss`.
- R6: The size codes are 00 = 4K (12 offset bits), 01 = 2M (21 offset bits) and 10 = 1G (30 offset bits). A hit matches the address bits above the offset for the entry's size. It returns `rsp_pa` built from the frame bits above that offset and the request's offset bits, and reports the code on `rsp_size`.
- R7: A fill always writes levels 0 and 1. It writes level 2 only for codes 00 and 01, so a 1G page evicted from levels 0 and 1 ends in a full miss. A fill with code 11 writes nothing.
- R8: Levels 0 and 1 replace entries round-robin: the ninth write into level 0 and the sixty-fifth write into level 1 overwrite the oldest entry.
- R9: A flush empties all levels in one cycle. It suppresses any response in that cycle and any later response of a lookup in progress. `req_ready` is 1 in the cycle after the flush.
- R10: `req_ready` is 0 while a lookup is past level 0, including the cycle of the miss report.
- R11: Level 2 is 4-way set associative, indexed by virtual address bits [18:12], with round-robin ways per set. A fifth page in one set evicts the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all levels and drop the lookup in progress |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | VA_W | Virtual address to translate |
| req_ready | output | 1 | Sequencer idle; a request is accepted this cycle |
| fill_valid | input | 1 | Walker fill strobe |
| fill_vpn | input | VA_W-12 | Virtual page number of the fill (4K units) |
| fill_ppn | input | PA_W-12 | Physical frame number of the fill (4K units) |
| fill_size | input | 2 | Size code of the fill |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | No level holds the page |
| rsp_pa | output | PA_W | Translated physical address (0 on a miss) |
| rsp_size | output | 2 | Size code of the hit entry |
| rsp_level | output | 2 | Level that answered, 11 on a miss |

## Verification
The due cycle of each response depends on where the page sits, so the bench sets that up first:
- A level-0 response is due in the request cycle.
- A level-1 response is due one edge later, and a level-2 response two edges later.
- A full miss is due three edges later.

The bench drives each request just after a falling edge. It samples 1 ns later and again after each later falling edge, and records the first cycle in which `rsp_valid` rises. That recorded latency is compared against the level the bench placed the page in. The bench places pages by counting the fills needed to evict them round-robin from the smaller levels. A flush is checked for silence in its own cycle and in each cycle where the dropped lookup would have answered.

// File: rtl/tlb3_pkg.sv
`timescale 1ns/1ps
package tlb3_pkg;

    // page size codes
    localparam logic [1:0] PG_4K  = 2'b00;
    localparam logic [1:0] PG_MID = 2'b01;
    localparam logic [1:0] PG_1G  = 2'b10;
    localparam logic [1:0] PG_BAD = 2'b11;

    // offset bits beyond the 4K offset, counted in page-number bits
    localparam int OFS_4K_BITS = 12;
    localparam int MID_SPAN    = 9;
    localparam int BIG_SPAN    = 18;

    // level codes on the response
    localparam logic [1:0] LVL_0    = 2'b00;
    localparam logic [1:0] LVL_1    = 2'b01;
    localparam logic [1:0] LVL_2    = 2'b10;
    localparam logic [1:0] LVL_NONE = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_L1   = 2'b01,
        ST_L2   = 2'b10,
        ST_MISS = 2'b11
    } lk_state_e;

endpackage

// File: rtl/tlb3_fa_level.sv
`timescale 1ns/1ps
module tlb3_fa_level
    import tlb3_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    output logic [1:0]       lk_size,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic [1:0]       wr_size
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    function automatic logic [VPN_W-1:0] vmask(input logic [1:0] sz);
        logic [VPN_W-1:0] m;
        m = '0;
        for (int b = 0; b < VPN_W; b++) begin
            if ((sz == PG_MID && b < MID_SPAN) || (sz == PG_1G && b < BIG_SPAN))
                m[b] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [PPN_W-1:0] pmask(input logic [1:0] sz);
        logic [PPN_W-1:0] m;
        m = '0;
        for (int b = 0; b < PPN_W; b++) begin
            if ((sz == PG_MID && b < MID_SPAN) || (sz == PG_1G && b < BIG_SPAN))
                m[b] = 1'b1;
        end
        return m;
    endfunction

    logic [ENTRIES-1:0] vld_q;
    logic [VPN_W-1:0]   tag_q  [ENTRIES];
    logic [PPN_W-1:0]   ppn_q  [ENTRIES];
    logic [1:0]         size_q [ENTRIES];
    logic [PTR_W-1:0]   ptr_q;
    logic [ENTRIES-1:0] match;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            logic [VPN_W-1:0] g_m;
            assign g_m      = vmask(size_q[g]);
            assign match[g] = vld_q[g] && ((lk_vpn & ~g_m) == tag_q[g]);
        end
    endgenerate

    always_comb begin
        lk_hit  = 1'b0;
        lk_ppn  = '0;
        lk_size = PG_4K;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                lk_hit  = 1'b1;
                lk_ppn  = ppn_q[i];
                lk_size = size_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            vld_q <= '0;
            ptr_q <= '0;
        end else if (wr_en) begin
            vld_q[ptr_q] <= 1'b1;
            ptr_q <= (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[ptr_q]  <= wr_vpn & ~vmask(wr_size);
            ppn_q[ptr_q]  <= wr_ppn & ~pmask(wr_size);
            size_q[ptr_q] <= wr_size;
        end
    end

endmodule

// File: rtl/tlb3_sa_level.sv
`timescale 1ns/1ps
module tlb3_sa_level
    import tlb3_pkg::*;
#(
    parameter int SETS  = 128,
    parameter int WAYS  = 4,
    parameter int VPN_W = 20,
    parameter int PPN_W = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic [$clog2(SETS)-1:0]  lk_idx,
    input  logic [VPN_W-1:0]         lk_vpn,
    output logic                     lk_hit,
    output logic [PPN_W-1:0]         lk_ppn,
    output logic [1:0]               lk_size,
    input  logic                     wr_en,
    input  logic [$clog2(SETS)-1:0]  wr_idx,
    input  logic [VPN_W-1:0]         wr_vpn,
    input  logic [PPN_W-1:0]         wr_ppn,
    input  logic [1:0]               wr_size
);
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    function automatic logic [VPN_W-1:0] vmask(input logic [1:0] sz);
        logic [VPN_W-1:0] m;
        m = '0;
        for (int b = 0; b < VPN_W; b++)
            if (sz == PG_MID && b < MID_SPAN) m[b] = 1'b1;
        return m;
    endfunction

    function automatic logic [PPN_W-1:0] pmask(input logic [1:0] sz);
        logic [PPN_W-1:0] m;
        m = '0;
        for (int b = 0; b < PPN_W; b++)
            if (sz == PG_MID && b < MID_SPAN) m[b] = 1'b1;
        return m;
    endfunction

    logic [WAYS-1:0]  vld_q  [SETS];
    logic [WAY_W-1:0] ptr_q  [SETS];
    logic [VPN_W-1:0] tag_q  [SETS][WAYS];
    logic [PPN_W-1:0] ppn_q  [SETS][WAYS];
    logic [1:0]       size_q [SETS][WAYS];
    logic [WAYS-1:0]  match;
    logic [IDX_W-1:0] set_sel;

    assign set_sel = lk_idx;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            logic [VPN_W-1:0] w_m;
            assign w_m      = vmask(size_q[set_sel][w]);
            assign match[w] = vld_q[set_sel][w] &&
                              ((lk_vpn & ~w_m) == tag_q[set_sel][w]);
        end
    endgenerate

    always_comb begin
        lk_hit  = 1'b0;
        lk_ppn  = '0;
        lk_size = PG_4K;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (match[i]) begin
                lk_hit  = 1'b1;
                lk_ppn  = ppn_q[set_sel][i];
                lk_size = size_q[set_sel][i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                ptr_q[s] <= '0;
            end
        end else if (wr_en) begin
            vld_q[wr_idx][ptr_q[wr_idx]] <= 1'b1;
            ptr_q[wr_idx] <= (ptr_q[wr_idx] == WAY_W'(WAYS - 1)) ? '0
                                                                 : ptr_q[wr_idx] + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx][ptr_q[wr_idx]]  <= wr_vpn & ~vmask(wr_size);
            ppn_q[wr_idx][ptr_q[wr_idx]]  <= wr_ppn & ~pmask(wr_size);
            size_q[wr_idx][ptr_q[wr_idx]] <= wr_size;
        end
    end

endmodule

// File: rtl/tlb3_pa_form.sv
`timescale 1ns/1ps
module tlb3_pa_form
    import tlb3_pkg::*;
#(
    parameter int VPN_W = 20,
    parameter int PPN_W = 20
) (
    input  logic [VPN_W-1:0] vpn,
    input  logic [PPN_W-1:0] ppn,
    input  logic [1:0]       size,
    output logic [PPN_W-1:0] ppn_out
);
    localparam int KEEP_W = (VPN_W < PPN_W) ? VPN_W : PPN_W;

    always_comb begin
        ppn_out = ppn;
        for (int b = 0; b < KEEP_W; b++) begin
            if ((size == PG_MID && b < MID_SPAN) || (size == PG_1G && b < BIG_SPAN))
                ppn_out[b] = vpn[b];
        end
    end

endmodule

// File: rtl/tlb3_hier.sv
`timescale 1ns/1ps
module tlb3_hier
    import tlb3_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int L0_N    = 8,
    parameter int L1_N    = 64,
    parameter int L2_SETS = 128,
    parameter int L2_WAYS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       req_valid,
    input  logic [VA_W-1:0]            req_va,
    output logic                       req_ready,
    input  logic                       fill_valid,
    input  logic [VA_W-OFS_4K_BITS-1:0] fill_vpn,
    input  logic [PA_W-OFS_4K_BITS-1:0] fill_ppn,
    input  logic [1:0]                 fill_size,
    output logic                       rsp_valid,
    output logic                       rsp_hit,
    output logic                       rsp_miss,
    output logic [PA_W-1:0]            rsp_pa,
    output logic [1:0]                 rsp_size,
    output logic [1:0]                 rsp_level
);
    localparam int VPN_W = VA_W - OFS_4K_BITS;
    localparam int PPN_W = PA_W - OFS_4K_BITS;
    localparam int IDX_W = $clog2(L2_SETS);

    lk_state_e state_q, state_d;
    logic [VA_W-1:0]  cap_va_q;
    logic             cap_en;
    logic [VPN_W-1:0] req_vpn, cap_vpn;

    logic             l0_hit, l1_hit, l2_hit;
    logic [PPN_W-1:0] l0_ppn, l1_ppn, l2_ppn;
    logic [1:0]       l0_size, l1_size, l2_size;

    logic             fill_ok, promo_l0, promo_l1;
    logic             l0_we, l1_we, l2_we;
    logic [VPN_W-1:0] up_vpn;
    logic [PPN_W-1:0] up_ppn;
    logic [1:0]       up_size;
    logic [VPN_W-1:0] l0_wvpn, l1_wvpn;
    logic [PPN_W-1:0] l0_wppn, l1_wppn;
    logic [1:0]       l0_wsize, l1_wsize;

    logic [VPN_W-1:0] pf_vpn;
    logic [PPN_W-1:0] pf_ppn, pf_out;
    logic [1:0]       pf_size;
    logic [11:0]      pf_ofs;

    assign req_vpn = req_va[VA_W-1:OFS_4K_BITS];
    assign cap_vpn = cap_va_q[VA_W-1:OFS_4K_BITS];

    // ---------------- levels ----------------
    tlb3_fa_level #(.ENTRIES(L0_N), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_l0 (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_vpn(req_vpn), .lk_hit(l0_hit), .lk_ppn(l0_ppn), .lk_size(l0_size),
        .wr_en(l0_we), .wr_vpn(l0_wvpn), .wr_ppn(l0_wppn), .wr_size(l0_wsize)
    );

    tlb3_fa_level #(.ENTRIES(L1_N), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_l1 (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_vpn(cap_vpn), .lk_hit(l1_hit), .lk_ppn(l1_ppn), .lk_size(l1_size),
        .wr_en(l1_we), .wr_vpn(l1_wvpn), .wr_ppn(l1_wppn), .wr_size(l1_wsize)
    );

    tlb3_sa_level #(.SETS(L2_SETS), .WAYS(L2_WAYS), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_l2 (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_idx(cap_vpn[IDX_W-1:0]), .lk_vpn(cap_vpn),
        .lk_hit(l2_hit), .lk_ppn(l2_ppn), .lk_size(l2_size),
        .wr_en(l2_we), .wr_idx(fill_vpn[IDX_W-1:0]), .wr_vpn(fill_vpn),
        .wr_ppn(fill_ppn), .wr_size(fill_size)
    );

    tlb3_pa_form #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_pa (
        .vpn(pf_vpn), .ppn(pf_ppn), .size(pf_size), .ppn_out(pf_out)
    );

    // ---------------- write steering ----------------
    // walker fill wins over promotion; code 11 is dropped
    assign fill_ok = fill_valid && (fill_size != PG_BAD);

    always_comb begin
        if (state_q == ST_L2) begin
            up_ppn  = l2_ppn;
            up_size = l2_size;
        end else begin
            up_ppn  = l1_ppn;
            up_size = l1_size;
        end
        up_vpn = cap_vpn;
    end

    assign l0_we    = fill_ok || promo_l0;
    assign l0_wvpn  = fill_ok ? fill_vpn  : up_vpn;
    assign l0_wppn  = fill_ok ? fill_ppn  : up_ppn;
    assign l0_wsize = fill_ok ? fill_size : up_size;

    assign l1_we    = fill_ok || promo_l1;
    assign l1_wvpn  = fill_ok ? fill_vpn  : up_vpn;
    assign l1_wppn  = fill_ok ? fill_ppn  : up_ppn;
    assign l1_wsize = fill_ok ? fill_size : up_size;

    assign l2_we    = fill_ok && (fill_size != PG_1G);

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cap_va_q <= '0;
        end else begin
            state_q <= state_d;
            if (cap_en) cap_va_q <= req_va;
        end
    end

    // ---------------- outputs and next state ----------------
    always_comb begin
        state_d   = state_q;
        cap_en    = 1'b0;
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_hit   = 1'b0;
        rsp_miss  = 1'b0;
        rsp_level = LVL_NONE;
        rsp_size  = PG_4K;
        promo_l0  = 1'b0;
        promo_l1  = 1'b0;
        pf_vpn    = cap_vpn;
        pf_ppn    = l1_ppn;
        pf_size   = l1_size;
        pf_ofs    = cap_va_q[11:0];

        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                pf_vpn    = req_vpn;
                pf_ppn    = l0_ppn;
                pf_size   = l0_size;
                pf_ofs    = req_va[11:0];
                if (req_valid) begin
                    if (l0_hit) begin
                        rsp_valid = 1'b1;
                        rsp_hit   = 1'b1;
                        rsp_level = LVL_0;
                        rsp_size  = l0_size;
                    end else begin
                        cap_en  = 1'b1;
                        state_d = ST_L1;
                    end
                end
            end
            ST_L1: begin
                if (l1_hit) begin
                    rsp_valid = 1'b1;
                    rsp_hit   = 1'b1;
                    rsp_level = LVL_1;
                    rsp_size  = l1_size;
                    promo_l0  = 1'b1;
                    state_d   = ST_IDLE;
                end else begin
                    state_d = ST_L2;
                end
            end
            ST_L2: begin
                pf_ppn  = l2_ppn;
                pf_size = l2_size;
                if (l2_hit) begin
                    rsp_valid = 1'b1;
                    rsp_hit   = 1'b1;
                    rsp_level = LVL_2;
                    rsp_size  = l2_size;
                    promo_l0  = 1'b1;
                    promo_l1  = 1'b1;
                    state_d   = ST_IDLE;
                end else begin
                    state_d = ST_MISS;
                end
            end
            ST_MISS: begin
                rsp_valid = 1'b1;
                rsp_miss  = 1'b1;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase

        if (flush) begin
            state_d   = ST_IDLE;
            cap_en    = 1'b0;
            req_ready = 1'b0;
            rsp_valid = 1'b0;
            rsp_hit   = 1'b0;
            rsp_miss  = 1'b0;
            rsp_level = LVL_NONE;
            promo_l0  = 1'b0;
            promo_l1  = 1'b0;
        end
    end

    assign rsp_pa = rsp_hit ? {pf_out, pf_ofs} : '0;

endmodule

// File: rtl/tlb3_hier_chk.sv
`timescale 1ns/1ps
module tlb3_hier_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       flush,
    input logic       req_valid,
    input logic       req_ready,
    input logic       rsp_valid,
    input logic       rsp_hit,
    input logic       rsp_miss,
    input logic [1:0] rsp_size,
    input logic [1:0] rsp_level
);
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit ^ rsp_miss));                                  // R5
    AST_L0_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_level == 2'b00) |-> (req_valid && req_ready));      // R2
    AST_L1_ONE_LATER: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_level == 2'b01) |-> $past(req_valid && req_ready)); // R3
    AST_MISS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_miss) |-> !req_ready);                              // R10
    AST_FLUSH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !rsp_valid);                                                // R9
    AST_FLUSH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (req_ready || flush));                                      // R9
    AST_NO_BIG_IN_L2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_level == 2'b10) |-> (rsp_size != 2'b10));           // R7
    AST_LEGAL_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_size != 2'b11));                                     // R6
endmodule

bind tlb3_hier tlb3_hier_chk u_chk (.*);

// File: tb/sim_tlb3_hier.sv
`timescale 1ns/1ps
module sim_tlb3_hier;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        flush;
    logic        req_valid;
    logic [31:0] req_va;
    logic        req_ready;
    logic        fill_valid;
    logic [19:0] fill_vpn;
    logic [19:0] fill_ppn;
    logic [1:0]  fill_size;
    logic        rsp_valid, rsp_hit, rsp_miss;
    logic [31:0] rsp_pa;
    logic [1:0]  rsp_size, rsp_level;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    tlb3_hier u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_va(req_va), .req_ready(req_ready),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_size(fill_size),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_pa(rsp_pa), .rsp_size(rsp_size), .rsp_level(rsp_level)
    );

    typedef struct packed {
        logic [19:0] fvpn;
        logic [19:0] fppn;
        logic [1:0]  fsz;
        logic [31:0] pva;
        logic [2:0]  lat;
        logic [1:0]  lvl;
        logic [31:0] pa;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{20'h12345, 20'h0ABCD, 2'b00, 32'h1234_5678, 3'd0, 2'b00, 32'h0ABC_D678}, // R2 R6 4K
        '{20'h40200, 20'h08000, 2'b01, 32'h403A_BCDE, 3'd0, 2'b00, 32'h081A_BCDE}, // R6 2M
        '{20'h80000, 20'h40000, 2'b10, 32'hBFFF_F123, 3'd0, 2'b00, 32'h7FFF_F123}, // R6 1G
        '{20'h40312, 20'h08111, 2'b01, 32'h4021_0000, 3'd0, 2'b00, 32'h0801_0000}, // R6 unaligned 2M
        '{20'h00001, 20'h00002, 2'b00, 32'h0000_2000, 3'd3, 2'b11, 32'h0000_0000}, // R5 neighbour page
        '{20'h80000, 20'h40000, 2'b10, 32'h7FFF_FFFF, 3'd3, 2'b11, 32'h0000_0000}, // R6 below 1G
        '{20'h33333, 20'h44444, 2'b11, 32'h3333_3000, 3'd3, 2'b11, 32'h0000_0000}  // R7 code 11
    };

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
    endtask

    task automatic do_fill(input logic [19:0] v, input logic [19:0] p, input logic [1:0] s);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = v; fill_ppn = p; fill_size = s;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] va, output int lat, output logic [1:0] lvl,
                          output logic [31:0] pa, output logic [1:0] sz, output logic rdy1);
        lat = -1; lvl = 2'b11; pa = '0; sz = '0; rdy1 = 1'b1;
        @(negedge clk); req_va = va; req_valid = 1'b1; #1;
        if (rsp_valid) begin lat = 0; lvl = rsp_level; pa = rsp_pa; sz = rsp_size; end
        @(negedge clk); req_valid = 1'b0; #1;
        for (int c = 1; c < 6 && lat < 0; c++) begin
            if (c == 1) rdy1 = req_ready;
            if (rsp_valid) begin
                lat = c; lvl = rsp_level; pa = rsp_pa; sz = rsp_size;
                if (rsp_miss == rsp_hit) check(1'b0, "R5 hit/miss flags", rsp_hit, rsp_miss);
            end else begin
                @(negedge clk); #1;
            end
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int lat; logic [1:0] lvl; logic [31:0] pa; logic [1:0] sz; logic r1;
        rst_n = 1'b0; flush = 1'b0; req_valid = 1'b0; req_va = '0;
        fill_valid = 1'b0; fill_vpn = '0; fill_ppn = '0; fill_size = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;

        // R1 reset state
        check(req_ready == 1'b1, "R1 req_ready after reset", req_ready, 1);
        check(rsp_valid == 1'b0, "R1 rsp_valid after reset", rsp_valid, 0);
        lookup(32'h1234_5678, lat, lvl, pa, sz, r1);
        check(lat == 3, "R1 empty after reset latency", lat, 3);

        // vector table
        for (int i = 0; i < NV; i++) begin
            do_flush();
            do_fill(VECS[i].fvpn, VECS[i].fppn, VECS[i].fsz);
            lookup(VECS[i].pva, lat, lvl, pa, sz, r1);
            check(lat == int'(VECS[i].lat), $sformatf("R6 vec%0d latency", i), lat, VECS[i].lat);
            check(lvl == VECS[i].lvl, $sformatf("R2 vec%0d level", i), lvl, VECS[i].lvl);
            check(pa == VECS[i].pa, $sformatf("R6 vec%0d pa", i), pa, VECS[i].pa);
            if (VECS[i].lat == 3'd0)
                check(sz == VECS[i].fsz, $sformatf("R6 vec%0d size", i), sz, VECS[i].fsz);
        end

        // R8 and R3: ninth fill evicts the first from level 0
        do_flush();
        for (int i = 0; i < 9; i++) do_fill(20'h00100 + 20'(i), 20'h00500 + 20'(i), 2'b00);
        lookup(32'h0010_0034, lat, lvl, pa, sz, r1);
        check(lat == 1, "R8 oldest evicted, R3 latency", lat, 1);
        check(lvl == 2'b01, "R3 level code", lvl, 1);
        check(pa == 32'h0050_0034, "R3 pa", pa, 32'h0050_0034);
        check(r1 == 1'b0, "R10 ready low during lookup", r1, 0);
        lookup(32'h0010_0034, lat, lvl, pa, sz, r1);
        check(lat == 0, "R3 promoted into level 0", lat, 0);
        lookup(32'h0010_8010, lat, lvl, pa, sz, r1);
        check(lat == 0 && pa == 32'h0050_8010, "R8 newest kept in level 0", pa, 32'h0050_8010);

        // R4: level 2 hit and copy into level 1
        do_flush();
        for (int i = 0; i < 65; i++) do_fill(20'h00200 + 20'(i), 20'h00700 + 20'(i), 2'b00);
        lookup(32'h0020_0ABC, lat, lvl, pa, sz, r1);
        check(lat == 2, "R4 latency", lat, 2);
        check(lvl == 2'b10 && pa == 32'h0070_0ABC, "R4 level and pa", pa, 32'h0070_0ABC);
        lookup(32'h0020_0ABC, lat, lvl, pa, sz, r1);
        check(lat == 0, "R4 copied into level 0", lat, 0);
        for (int j = 0; j < 8; j++) do_fill(20'h00300 + 20'(j), 20'h00800 + 20'(j), 2'b00);
        lookup(32'h0020_0ABC, lat, lvl, pa, sz, r1);
        check(lat == 1, "R4 copied into level 1", lat, 1);

        // R7: 1G never kept in level 2
        do_flush();
        do_fill(20'h80000, 20'h40000, 2'b10);
        for (int i = 0; i < 64; i++) do_fill(20'h00400 + 20'(i), 20'h00900 + 20'(i), 2'b00);
        lookup(32'h8000_0123, lat, lvl, pa, sz, r1);
        check(lat == 3, "R7 1G not in level 2", lat, 3);

        // R7: 2M kept in level 2
        do_flush();
        do_fill(20'h40200, 20'h08000, 2'b01);
        for (int i = 0; i < 64; i++) do_fill(20'h00400 + 20'(i), 20'h00900 + 20'(i), 2'b00);
        lookup(32'h4020_0ABC, lat, lvl, pa, sz, r1);
        check(lat == 2 && pa == 32'h0800_0ABC, "R7 2M from level 2", pa, 32'h0800_0ABC);
        check(sz == 2'b01, "R7 2M size code", sz, 1);

        // R11: fifth page in one set evicts the first
        do_flush();
        for (int k = 1; k <= 5; k++) do_fill(20'(k << 7), 20'h00A00 + 20'(k), 2'b00);
        for (int i = 0; i < 64; i++) do_fill(20'h01001 + 20'(i), 20'h00B00 + 20'(i), 2'b00);
        lookup(32'h0008_0000, lat, lvl, pa, sz, r1);
        check(lat == 3, "R11 first way evicted", lat, 3);
        lookup(32'h0010_0000, lat, lvl, pa, sz, r1);
        check(lat == 2 && pa == 32'h00A0_2000, "R11 second way kept", pa, 32'h00A0_2000);

        // R9: flush during a lookup
        do_flush();
        do_fill(20'h00111, 20'h00222, 2'b00);
        @(negedge clk); req_va = 32'h5555_5000; req_valid = 1'b1; #1;
        check(rsp_valid == 1'b0, "R9 request cycle no response", rsp_valid, 0);
        @(negedge clk); req_valid = 1'b0; flush = 1'b1; #1;
        check(rsp_valid == 1'b0, "R9 no response in flush cycle", rsp_valid, 0);
        @(negedge clk); flush = 1'b0; #1;
        check(req_ready == 1'b1, "R9 ready after flush", req_ready, 1);
        for (int c = 0; c < 3; c++) begin
            check(rsp_valid == 1'b0, "R9 dropped lookup silent", rsp_valid, 0);
            @(negedge clk); #1;
        end
        lookup(32'h0011_1000, lat, lvl, pa, sz, r1);
        check(lat == 3, "R9 flush emptied levels", lat, 3);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule